// File: doc/BRIEF.md
# Audio Effects DSP Arithmetic Core

This block is the arithmetic heart of a sample-rate audio effects engine that runs a fixed-length microprogram of 128 steps for every audio sample. On each enabled clock it carries out one already-decoded instruction. It picks an X operand, either the external input word or an entry of a 128-deep scratch ring. It picks a 13-bit signed Y multiplier from a coefficient, a fraction register or slices of a Y holding register. It picks a B addend. From these it forms a new 26-bit accumulator. Alongside that, a shifter scales and limits the accumulator value left by the previous step. Its result can be written back into the scratch ring, into the fraction register, or added into one of sixteen effect output accumulators.

Instruction decode, external memory addressing and the input-bus multiplexer live outside this block. The surrounding sequencer drives the decoded fields, the 24-bit input operand, the 16-bit coefficient and the ring offset each step. It pulses a start strobe at the top of every sample and holds the enable low while no program is loaded.

Top module: `afx_dsp_core`

## Requirements
- R1: After reset the accumulator, every effect output, the step counter, the fraction register, the Y holding register and every scratch ring entry are zero.
- R2: X is `in_opnd` when `x_from_in`=1. Otherwise it is the ring entry at index (`tmp_rd_idx` + `ring_ofs`) mod 128, taken as a 24-bit signed value.
- R3: `y_sel` encodes the Y source. 0 is the 13-bit fraction register. 1 is `coef[15:3]`. 2 is holding-register bits 23:11. 3 is holding-register bits 15:4 with a zero on top. The 13-bit result is treated as signed.
- R4: B is zero when `b_zero`=1. Otherwise it is the current accumulator when `b_from_acc`=1, or else the indexed ring entry sign-extended to 26 bits. When `b_neg`=1 and `b_zero`=0, B is negated.
- R5: On an executed step the accumulator becomes ((X*Y) arithmetically shifted right by 10, kept to 26 bits) + B, kept to 26 bits signed. `acc_o` shows it from the following clock.
- R6: `shf_o` is derived from the accumulator held before the current step. With `shift_mode` 0 it is acc>>>2 and with mode 1 it is acc>>>1, both limited to -0x80000..0x7FFFF. With mode 2 it is acc>>>1 and with mode 3 it is acc>>>2, both wrapped to 24 bits.
- R7: When `tmp_wr_en`=1 on an executed step, `shf_o` is stored at ring index (`tmp_wr_idx` + `ring_ofs`) mod 128. A read of the same index in that step returns the old content.
- R8: When `frc_load`=1 the fraction register takes `shf_o[11:0]` (zero-extended) if `shift_mode`=3, and `shf_o[23:11]` otherwise.
- R9: When `yhold_load`=1 the holding register takes `in_opnd`. The Y value used in that same step comes from the old holding register.
- R10: When `efx_wr_en`=1, effect output `efx_idx` (at `efx_o[24*i +: 24]`) adds `shf_o` arithmetically shifted right by 4, wrapping at 24 bits.
- R11: A cycle with `sample_start`=1 clears all effect outputs and the step counter. No instruction is executed in that cycle, so the accumulator and ring keep their values.
- R12: A cycle with `run_en`=0 and `sample_start`=0 changes no state, whatever the instruction fields hold.
- R13: `step_o` counts executed steps modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_start | input | 1 | Top-of-sample strobe |
| run_en | input | 1 | Program loaded; execute steps |
| x_from_in | input | 1 | X from input operand |
| y_sel | input | 2 | Y source select |
| b_zero | input | 1 | Force B to zero |
| b_from_acc | input | 1 | B from accumulator |
| b_neg | input | 1 | Negate B |
| tmp_rd_idx | input | 7 | Ring read index before offset |
| tmp_wr_en | input | 1 | Write shifter result to ring |
| tmp_wr_idx | input | 7 | Ring write index before offset |
| shift_mode | input | 2 | Shifter mode |
| frc_load | input | 1 | Load fraction register |
| yhold_load | input | 1 | Load Y holding register |
| efx_wr_en | input | 1 | Accumulate into effect output |
| efx_idx | input | 4 | Effect output index |
| in_opnd | input | 24 | Input operand |
| coef | input | 16 | Step coefficient |
| ring_offset | input | 7 | Ring offset counter |
| acc_o | output | 26 | Accumulator |
| shf_o | output | 24 | Shifter output |
| efx_o | output | 384 | Sixteen 24-bit effect outputs |
| step_o | output | 7 | Step counter |

## Verification
The bench builds the core with its default parameters: a 128-entry ring, 24-bit data, 13-bit Y and sixteen outputs. At that size it sweeps every combination of X source, Y source, B control and shifter mode several times, with random indices, offsets and operands and a steady share of full-scale inputs. The accumulator therefore grows large enough to reach both limits of the saturating modes and the wrap of the others. Runs of 256 steps carry the step counter across its wrap. Idle cycles that carry write fields, and reads of the same ring entry afterwards, show that nothing moved while the core was held.

// File: rtl/afx_dsp_pkg.sv
package afx_dsp_pkg;
   typedef enum logic [1:0] {
      SHM_SAT_Q2  = 2'd0,
      SHM_SAT_Q1  = 2'd1,
      SHM_WRAP_Q1 = 2'd2,
      SHM_WRAP_Q2 = 2'd3
   } afx_shm_e;

   typedef enum logic [1:0] {
      YSRC_FRC  = 2'd0,
      YSRC_COEF = 2'd1,
      YSRC_HIGH = 2'd2,
      YSRC_MID  = 2'd3
   } afx_ysrc_e;
endpackage

// File: rtl/afx_temp_ring.sv
module afx_temp_ring #(
   parameter int DW    = 24,
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data
);
   logic [DW-1:0] mem_q [DEPTH];

   // read is combinational: a same-step write lands after the read
   assign rd_data = mem_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[wr_idx] <= wr_data;
      end
   end
endmodule

// File: rtl/afx_operand_sel.sv
module afx_operand_sel
   import afx_dsp_pkg::*;
#(
   parameter int DW    = 24,
   parameter int YW    = 13,
   parameter int CW    = 16,
   parameter int ACC_W = 26
) (
   input  logic                    x_from_in,
   input  logic [1:0]              y_sel,
   input  logic                    b_zero,
   input  logic                    b_from_acc,
   input  logic                    b_neg,
   input  logic [DW-1:0]           tmp_val,
   input  logic [DW-1:0]           in_opnd,
   input  logic [CW-1:0]           coef,
   input  logic [YW-1:0]           frc_q,
   input  logic [DW-1:0]           yh_q,
   input  logic [ACC_W-1:0]        acc_q,
   output logic signed [DW-1:0]    x_op,
   output logic signed [YW-1:0]    y_op,
   output logic signed [ACC_W-1:0] b_op
);
   localparam int MID_TOP = DW - 9;
   localparam int LOW_UNUSED = DW - YW - 8;

   logic signed [ACC_W-1:0] tmp_ext;
   logic signed [ACC_W-1:0] b_raw;
   logic                    unused_low_bits;

   assign unused_low_bits = ^{coef[CW-YW-1:0], yh_q[LOW_UNUSED:0]};

   assign x_op    = x_from_in ? in_opnd : tmp_val;
   assign tmp_ext = ACC_W'(signed'(tmp_val));

   always_comb begin
      unique case (afx_ysrc_e'(y_sel))
         YSRC_FRC:  y_op = frc_q;
         YSRC_COEF: y_op = coef[CW-1 -: YW];
         YSRC_HIGH: y_op = yh_q[DW-1 -: YW];
         default:   y_op = {1'b0, yh_q[MID_TOP -: YW-1]};
      endcase
   end

   always_comb begin
      b_raw = b_from_acc ? signed'(acc_q) : tmp_ext;
      if (b_zero)      b_op = '0;
      else if (b_neg)  b_op = -b_raw;
      else             b_op = b_raw;
   end
endmodule

// File: rtl/afx_mac.sv
module afx_mac #(
   parameter int DW     = 24,
   parameter int YW     = 13,
   parameter int ACC_W  = 26,
   parameter int PROD_SHR = 10,
   localparam int PW    = DW + YW
) (
   input  logic signed [DW-1:0]    x_op,
   input  logic signed [YW-1:0]    y_op,
   input  logic signed [ACC_W-1:0] b_op,
   output logic [ACC_W-1:0]        acc_next
);
   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] prod_t;

   assign prod     = PW'(x_op) * PW'(y_op);
   assign prod_t   = ACC_W'(prod >>> PROD_SHR);
   assign acc_next = prod_t + b_op;
endmodule

// File: rtl/afx_shifter.sv
module afx_shifter
   import afx_dsp_pkg::*;
#(
   parameter int ACC_W = 26,
   parameter int DW    = 24,
   parameter int SAT_W = 20
) (
   input  logic [ACC_W-1:0] acc_q,
   input  logic [1:0]       mode,
   output logic [DW-1:0]    shf
);
   logic signed [ACC_W-1:0] a;
   logic signed [ACC_W-1:0] q1;
   logic signed [ACC_W-1:0] q2;
   logic signed [ACC_W-1:0] q1_lim;
   logic signed [ACC_W-1:0] q2_lim;

   assign a  = signed'(acc_q);
   assign q1 = a >>> 1;
   assign q2 = a >>> 2;

   generate
      if (SAT_W < ACC_W - 1) begin : g_clamp
         localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'((64'sd1 <<< (SAT_W - 1)) - 64'sd1);
         localparam logic signed [ACC_W-1:0] LIM_LO = ~LIM_HI;
         assign q1_lim = (q1 > LIM_HI) ? LIM_HI : (q1 < LIM_LO) ? LIM_LO : q1;
         assign q2_lim = (q2 > LIM_HI) ? LIM_HI : (q2 < LIM_LO) ? LIM_LO : q2;
      end else begin : g_noclamp
         assign q1_lim = q1;
         assign q2_lim = q2;
      end
   endgenerate

   always_comb begin
      unique case (afx_shm_e'(mode))
         SHM_SAT_Q2:  shf = q2_lim[DW-1:0];
         SHM_SAT_Q1:  shf = q1_lim[DW-1:0];
         SHM_WRAP_Q1: shf = q1[DW-1:0];
         default:     shf = q2[DW-1:0];
      endcase
   end
endmodule

// File: rtl/afx_efx_bank.sv
module afx_efx_bank #(
   parameter int DW    = 24,
   parameter int EW    = 24,
   parameter int N_OUT = 16,
   parameter int SHR   = 4,
   localparam int IW   = $clog2(N_OUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IW-1:0]     idx,
   input  logic [DW-1:0]     shf,
   output logic [N_OUT*EW-1:0] efx_flat
);
   logic signed [EW-1:0] add_val;

   assign add_val = EW'(signed'(shf) >>> SHR);

   for (genvar gi = 0; gi < N_OUT; gi++) begin : g_ent
      logic [EW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          r_q <= '0;
         else if (clr)                        r_q <= '0;
         else if (wr_en && idx == IW'(gi))    r_q <= r_q + add_val;
      end
      assign efx_flat[gi*EW +: EW] = r_q;
   end
endmodule

// File: rtl/afx_dsp_core.sv
module afx_dsp_core
   import afx_dsp_pkg::*;
#(
   parameter int DW       = 24,
   parameter int YW       = 13,
   parameter int CW       = 16,
   parameter int ACC_W    = 26,
   parameter int PROD_SHR = 10,
   parameter int SAT_W    = 20,
   parameter int TMP_DEPTH = 128,
   parameter int STEPS    = 128,
   parameter int N_EFX    = 16,
   parameter int EW       = 24,
   parameter int EFX_SHR  = 4,
   localparam int TA      = $clog2(TMP_DEPTH),
   localparam int EI      = $clog2(N_EFX),
   localparam int SW      = $clog2(STEPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sample_start,
   input  logic                 run_en,
   input  logic                 x_from_in,
   input  logic [1:0]           y_sel,
   input  logic                 b_zero,
   input  logic                 b_from_acc,
   input  logic                 b_neg,
   input  logic [TA-1:0]        tmp_rd_idx,
   input  logic                 tmp_wr_en,
   input  logic [TA-1:0]        tmp_wr_idx,
   input  logic [1:0]           shift_mode,
   input  logic                 frc_load,
   input  logic                 yhold_load,
   input  logic                 efx_wr_en,
   input  logic [EI-1:0]        efx_idx,
   input  logic [DW-1:0]        in_opnd,
   input  logic [CW-1:0]        coef,
   input  logic [TA-1:0]        ring_offset,
   output logic [ACC_W-1:0]     acc_o,
   output logic [DW-1:0]        shf_o,
   output logic [N_EFX*EW-1:0]  efx_o,
   output logic [SW-1:0]        step_o
);
   if ((1 << TA) != TMP_DEPTH) begin : g_bad_depth
      $error("TMP_DEPTH must be a power of two");
   end
   if ((1 << SW) != STEPS) begin : g_bad_steps
      $error("STEPS must be a power of two");
   end
   if (ACC_W > DW + YW - PROD_SHR) begin : g_bad_acc
      $error("ACC_W exceeds the shifted product width");
   end
   if (YW >= CW || YW > DW - 8) begin : g_bad_yw
      $error("YW does not fit the coefficient or holding-register slices");
   end
   if (SAT_W > DW || ACC_W < DW + 2) begin : g_bad_sat
      $error("shifter widths inconsistent");
   end

   logic                    exec;
   logic [ACC_W-1:0]        acc_q, acc_next;
   logic [YW-1:0]           frc_q;
   logic [DW-1:0]           yh_q;
   logic [SW-1:0]           step_q;
   logic [DW-1:0]           tmp_val, shf;
   logic [TA-1:0]           rd_addr, wr_addr;
   logic signed [DW-1:0]    x_op;
   logic signed [YW-1:0]    y_op;
   logic signed [ACC_W-1:0] b_op;

   assign exec    = run_en & ~sample_start;
   assign rd_addr = tmp_rd_idx + ring_offset;
   assign wr_addr = tmp_wr_idx + ring_offset;

   afx_temp_ring #(.DW(DW), .DEPTH(TMP_DEPTH)) u_ring (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_addr), .rd_data(tmp_val),
      .wr_en(exec & tmp_wr_en), .wr_idx(wr_addr), .wr_data(shf)
   );

   afx_operand_sel #(.DW(DW), .YW(YW), .CW(CW), .ACC_W(ACC_W)) u_opsel (
      .x_from_in(x_from_in), .y_sel(y_sel), .b_zero(b_zero),
      .b_from_acc(b_from_acc), .b_neg(b_neg), .tmp_val(tmp_val),
      .in_opnd(in_opnd), .coef(coef), .frc_q(frc_q), .yh_q(yh_q),
      .acc_q(acc_q), .x_op(x_op), .y_op(y_op), .b_op(b_op)
   );

   afx_mac #(.DW(DW), .YW(YW), .ACC_W(ACC_W), .PROD_SHR(PROD_SHR)) u_mac (
      .x_op(x_op), .y_op(y_op), .b_op(b_op), .acc_next(acc_next)
   );

   afx_shifter #(.ACC_W(ACC_W), .DW(DW), .SAT_W(SAT_W)) u_shift (
      .acc_q(acc_q), .mode(shift_mode), .shf(shf)
   );

   afx_efx_bank #(.DW(DW), .EW(EW), .N_OUT(N_EFX), .SHR(EFX_SHR)) u_efx (
      .clk(clk), .rst_n(rst_n), .clr(sample_start),
      .wr_en(exec & efx_wr_en), .idx(efx_idx), .shf(shf), .efx_flat(efx_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         frc_q  <= '0;
         yh_q   <= '0;
         step_q <= '0;
      end else if (sample_start) begin
         step_q <= '0;
      end else if (exec) begin
         acc_q  <= acc_next;
         step_q <= step_q + 1'b1;
         if (yhold_load) yh_q <= in_opnd;
         if (frc_load) begin
            if (afx_shm_e'(shift_mode) == SHM_WRAP_Q2) frc_q <= {1'b0, shf[YW-2:0]};
            else                                       frc_q <= shf[DW-1 -: YW];
         end
      end
   end

   assign acc_o  = acc_q;
   assign shf_o  = shf;
   assign step_o = step_q;
endmodule

// File: rtl/afx_dsp_core_chk.sv
module afx_dsp_core_chk #(
   parameter int ACC_W = 26,
   parameter int DW    = 24,
   parameter int SAT_W = 20,
   parameter int NEW   = 384,
   parameter int SW    = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_start,
   input logic             run_en,
   input logic [1:0]       shift_mode,
   input logic [ACC_W-1:0] acc_o,
   input logic [DW-1:0]    shf_o,
   input logic [NEW-1:0]   efx_o,
   input logic [SW-1:0]    step_o
);
   localparam logic signed [DW-1:0] LIM_HI = DW'((64'sd1 <<< (SAT_W - 1)) - 64'sd1);
   localparam logic signed [DW-1:0] LIM_LO = ~LIM_HI;

   assert_step_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sample_start |=> step_o == '0);
   assert_efx_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sample_start |=> efx_o == '0);
   assert_acc_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sample_start |=> acc_o == $past(acc_o));
   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !sample_start) |=> ($stable(acc_o) && $stable(step_o) && $stable(efx_o)));
   assert_step_count_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !sample_start) |=> step_o == SW'($past(step_o) + 1'b1));
   assert_sat_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_mode[1] |-> (signed'(shf_o) <= LIM_HI && signed'(shf_o) >= LIM_LO));
endmodule

bind afx_dsp_core afx_dsp_core_chk #(
   .ACC_W(ACC_W), .DW(DW), .SAT_W(SAT_W), .NEW(N_EFX*EW), .SW(SW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_start(sample_start), .run_en(run_en),
   .shift_mode(shift_mode), .acc_o(acc_o), .shf_o(shf_o), .efx_o(efx_o),
   .step_o(step_o)
);

// File: tb/afx_dsp_core_bench.sv
module afx_dsp_core_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_start = 1'b0, run_en = 1'b0;
   logic x_from_in = 1'b0, b_zero = 1'b0, b_from_acc = 1'b0, b_neg = 1'b0;
   logic [1:0] y_sel = '0, shift_mode = '0;
   logic [6:0] tmp_rd_idx = '0, tmp_wr_idx = '0, ring_offset = '0;
   logic tmp_wr_en = 1'b0, frc_load = 1'b0, yhold_load = 1'b0, efx_wr_en = 1'b0;
   logic [3:0] efx_idx = '0;
   logic [23:0] in_opnd = '0;
   logic [15:0] coef = '0;
   logic [25:0] acc_o;
   logic [23:0] shf_o;
   logic [383:0] efx_o;
   logic [6:0] step_o;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // reference state
   longint m_acc, m_tmp[128], m_frc, m_yh, m_efx[16];
   int m_step;

   always #(CLK_PERIOD/2) clk = ~clk;

   afx_dsp_core u_afx_dsp_core (
      .clk(clk), .rst_n(rst_n), .sample_start(sample_start), .run_en(run_en),
      .x_from_in(x_from_in), .y_sel(y_sel), .b_zero(b_zero), .b_from_acc(b_from_acc),
      .b_neg(b_neg), .tmp_rd_idx(tmp_rd_idx), .tmp_wr_en(tmp_wr_en),
      .tmp_wr_idx(tmp_wr_idx), .shift_mode(shift_mode), .frc_load(frc_load),
      .yhold_load(yhold_load), .efx_wr_en(efx_wr_en), .efx_idx(efx_idx),
      .in_opnd(in_opnd), .coef(coef), .ring_offset(ring_offset),
      .acc_o(acc_o), .shf_o(shf_o), .efx_o(efx_o), .step_o(step_o)
   );

   function automatic longint sx(longint v, int w);
      longint one = 1;
      longint r = v & ((one << w) - 1);
      if (((r >> (w - 1)) & 1) == 1) r = r - (one << w);
      return r;
   endfunction

   function automatic longint mshift(longint a, int m);
      longint v;
      case (m)
         0: v = a >>> 2;
         1: v = a >>> 1;
         2: v = sx(a >>> 1, 24);
         default: v = sx(a >>> 2, 24);
      endcase
      if (m < 2) begin
         if (v > 524287) v = 524287;
         if (v < -524288) v = -524288;
      end
      return v;
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_state(string req);
      int bad = -1;
      chk(req, "acc", sx(longint'(acc_o), 26), m_acc);
      chk(req, "step", longint'(step_o), longint'(m_step));
      for (int i = 0; i < 16; i++)
         if (bad < 0 && longint'(efx_o[i*24 +: 24]) != m_efx[i]) bad = i;
      if (bad < 0) chk(req, "efx", 0, 0);
      else chk(req, $sformatf("efx[%0d]", bad), longint'(efx_o[bad*24 +: 24]), m_efx[bad]);
   endtask

   task automatic drive(int xs, int ys, int bz, int ba, int bn, int tra, int twt, int twa,
                        int sm, int frcl, int yrl, int ewt, int ewa, longint inv,
                        longint cf, int ring);
      x_from_in = 1'(xs); y_sel = 2'(ys); b_zero = 1'(bz); b_from_acc = 1'(ba);
      b_neg = 1'(bn); tmp_rd_idx = 7'(tra); tmp_wr_en = 1'(twt); tmp_wr_idx = 7'(twa);
      shift_mode = 2'(sm); frc_load = 1'(frcl); yhold_load = 1'(yrl);
      efx_wr_en = 1'(ewt); efx_idx = 4'(ewa); in_opnd = 24'(inv); coef = 16'(cf);
      ring_offset = 7'(ring);
   endtask

   // one executed step: R2..R10 through acc/shf/efx, R13 through step
   task automatic exec_step(int xs, int ys, int bz, int ba, int bn, int tra, int twt, int twa,
                            int sm, int frcl, int yrl, int ewt, int ewa, longint inv,
                            longint cf, int ring);
      longint sh, t, x, y, b, p;
      @(negedge clk);
      drive(xs, ys, bz, ba, bn, tra, twt, twa, sm, frcl, yrl, ewt, ewa, inv, cf, ring);
      run_en = 1'b1; sample_start = 1'b0;
      #1;
      sh = mshift(m_acc, sm);
      chk("R6", "shf", sx(longint'(shf_o), 24), sh);
      t = sx(m_tmp[(tra + ring) % 128], 24);
      x = xs ? sx(inv, 24) : t;
      case (ys)
         0: y = m_frc;
         1: y = (cf >> 3) & 'h1FFF;
         2: y = (m_yh >> 11) & 'h1FFF;
         default: y = (m_yh >> 4) & 'hFFF;
      endcase
      y = sx(y, 13);
      b = bz ? 0 : (ba ? m_acc : t);
      if (!bz && bn) b = -b;
      p = sx((x * y) >>> 10, 26);
      m_acc = sx(p + b, 26);
      if (twt) m_tmp[(twa + ring) % 128] = sh & 'hFFFFFF;
      if (frcl) m_frc = (sm == 3) ? (sh & 'hFFF) : ((sh >> 11) & 'h1FFF);
      if (yrl) m_yh = inv & 'hFFFFFF;
      if (ewt) m_efx[ewa] = (m_efx[ewa] + (sh >>> 4)) & 'hFFFFFF;
      m_step = (m_step + 1) % 128;
      @(posedge clk); #1;
      chk_state("R2/R3/R4/R5/R7/R8/R9/R10/R13");
   endtask

   task automatic start_pulse();
      @(negedge clk);
      drive(1, 1, 0, 0, 0, 3, 1, 3, 0, 1, 1, 1, 0, 'h7FFFFF, 'h7FFF, 9);
      run_en = 1'b1; sample_start = 1'b1;
      for (int i = 0; i < 16; i++) m_efx[i] = 0;
      m_step = 0;
      @(posedge clk); #1;
      chk_state("R11");
      sample_start = 1'b0;
   endtask

   function automatic longint pick24(int k);
      case (k % 5)
         0: return 'h7FFFFF;
         1: return 'h800000;
         default: return longint'($urandom) & 'hFFFFFF;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_acc = 0; m_frc = 0; m_yh = 0; m_step = 0;
      for (int i = 0; i < 128; i++) m_tmp[i] = 0;
      for (int i = 0; i < 16; i++) m_efx[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk_state("R1");
      // R1: zero ring and zero holding registers give zero products
      exec_step(0, 2, 0, 0, 0, 77, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      exec_step(0, 1, 0, 0, 1, 5, 0, 0, 3, 0, 0, 0, 0, 0, 'h7FF8, 0);
      // directed: build a large positive accumulator and observe wrap/clamp
      exec_step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 'h7FFFFF, 'h7FF8, 0);
      exec_step(1, 2, 0, 1, 0, 0, 1, 5, 1, 1, 0, 1, 2, 'h7FFFFF, 0, 0);
      exec_step(0, 0, 0, 1, 1, 5, 1, 6, 2, 1, 0, 1, 2, 0, 0, 0);
      exec_step(0, 3, 0, 0, 0, 6, 0, 0, 3, 1, 1, 1, 15, 'h800000, 0, 0);
      // R12: idle with write fields set must leave everything in place
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         drive(1, 1, 0, 1, 1, 5, 1, 5, i, 1, 1, 1, 2, 'h123456, 'h7FF8, 0);
         run_en = 1'b0; sample_start = 1'b0;
         @(posedge clk); #1;
         chk_state("R12");
      end
      // R12: ring entry 5 must still hold the pre-idle value
      exec_step(0, 1, 0, 0, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 'h7FF8, 0);
      // R7: same-step read of the entry being written returns old content
      exec_step(0, 1, 0, 0, 0, 9, 1, 9, 2, 0, 0, 0, 0, 0, 'h4000, 0);
      exec_step(0, 1, 0, 0, 0, 9, 0, 0, 2, 0, 0, 0, 0, 0, 'h4000, 0);
      start_pulse();
      // sweep: every x/y/b/shift combination, four passes of 256 steps
      for (int pass = 0; pass < 4; pass++) begin
         for (int k = 0; k < 256; k++) begin
            int r = int'($urandom);
            exec_step(k & 1, (k >> 1) & 3, (k >> 3) & 1, (k >> 4) & 1, (k >> 5) & 1,
                      int'($urandom % 128), r & 1, int'($urandom % 128), (k >> 6) & 3,
                      (r >> 1) & 1, (r >> 2) & 1, (r >> 3) & 1, (r >> 4) & 15,
                      pick24(k + pass), longint'($urandom) & 'hFFFF,
                      (pass == 0) ? 0 : int'($urandom % 128));
            if ((r & 'h3F00) == 0) begin
               @(negedge clk);
               drive(1, 3, 0, 0, 0, 1, 1, k & 127, 1, 1, 1, 1, 3, 'hABCDEF, 'h1234, 0);
               run_en = 1'b0;
               @(posedge clk); #1;
               chk_state("R12");
            end
         end
         start_pulse();
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule